// File: doc/BRIEF.md
# Daisy-Chainable SPI Target Shift Path

This block is the serial datapath on the target side of a converter that can be wired into a chain of identical devices. Each device's serial output feeds the serial input of the next, and every device shares the host's chip select and serial clock. While chip select is low, the block first sends its own output frame, most significant bit first. That frame is a data word, optionally with a status header and a CRC, and it is supplied on a parallel input. Once all of its own frame bits are out, the block forwards the bits it has received on its serial input. The frame of a device further up the chain therefore reaches the host right after this device's own frame.

The length of a frame in bits comes from a two-bit configuration select and is fixed when chip select falls. When chip select rises, the block takes the last frame-length bits it received and presents them as a command word with a one-cycle valid strobe. If too few bits arrived, it raises a one-cycle frame-error strobe instead. Command decoding, register storage, CRC generation and the conversion itself belong to neighbouring blocks. A continuous-read control input turns the forwarding off, because chaining requires that mode to be disabled.

All serial inputs are oversampled by the block's system clock through synchronizers. Serial input is sampled on rising SCLK edges, and serial output advances on falling SCLK edges. The output is presented with an enable that is released while chip select is high, and the board pulls the line up in that state.

Top module: `dspi_chain_target`

## Requirements
- R1: The frame length L follows `cfg_frame_sel`: 2'b00 gives 24 bits (24-bit data), 2'b01 gives 32 (24-bit data with CRC), 2'b10 gives 48 (status header, 24-bit data and CRC), and 2'b11 gives 24 (16-bit data with CRC). The select is captured when chip select falls, and a change during an active frame has no effect on that frame.
- R2: When chip select falls, `tx_frame` is captured and `tx_frame[L-1]` appears on `sdo`. Each falling SCLK edge that follows moves to the next lower bit, down to `tx_frame[0]`. A change of `tx_frame` during the frame has no effect on that frame.
- R3: With `cont_read_en` low, once the L own bits are out, `sdo` carries the bits received on `sdi` in arrival order, delayed by exactly L SCLK periods. The host reads the k-th received bit (k from 0) at the rising edge numbered L+k+1.
- R4: With `cont_read_en` high, `sdo` stays at 1 after the L own bits instead of forwarding `sdi`.
- R5: SCLK edges while chip select is high are ignored. They neither add to the received bit count nor shift the receive register.
- R6: When chip select rises after at least L rising SCLK edges, `cmd_valid` pulses for one clock. `cmd_word[L-1:0]` then holds the last L received bits, with the most recent bit in bit 0, and the bits above L-1 are 0.
- R7: When chip select rises after fewer than L rising SCLK edges, `frame_err` pulses for one clock. In that case `cmd_valid` stays low and `cmd_word` keeps its previous value.
- R8: `sdo_oe` is 1 while chip select is low and 0 while it is high. With the output released, the pulled-up line reads 1.
- R9: After reset, `sdo_oe`, `cmd_valid` and `frame_err` are 0 and `cmd_word` is 0.
- R10: `sdo` changes only in response to a falling chip select or a falling SCLK edge. It is stable across rising SCLK edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in, from the host or the upstream device |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| cfg_frame_sel | input | 2 | Frame length select |
| cont_read_en | input | 1 | Continuous-read mode, disables forwarding |
| tx_frame | input | MAX_FRAME | Own output frame, right-aligned to L bits |
| cmd_word | output | MAX_FRAME | Last L received bits, captured at chip select rise |
| cmd_valid | output | 1 | One-clock strobe when cmd_word is updated |
| frame_err | output | 1 | One-clock strobe when a frame was too short |

## Verification
The most sensitive corner is the switch from the device's own bits to forwarded bits. A one-bit pass register instead of an L-bit delay would drop the upstream device's frame, and an off-by-one would shift every forwarded bit. The bench therefore drives streams well past L for every length select and compares each sampled bit. Frames one bit short, and SCLK toggling while deselected, are used to expose a counter that saturates wrongly or keeps counting while chip select is high; such a design would issue a command where a frame error is due. Mid-frame changes of the length select and of the data word catch a design that reads those inputs live, and continuous-read frames catch forwarding that is not gated by that control.

// File: rtl/dspi_pkg.sv
`timescale 1ns/1ps
package dspi_pkg;

  // width of every bit count and frame length in the block
  localparam int unsigned LEN_W = 8;

  typedef logic [LEN_W-1:0] len_t;

  // frame-length select encoding
  typedef enum logic [1:0] {
    FRM_D24         = 2'b00,
    FRM_D24_CRC     = 2'b01,
    FRM_D24_STS_CRC = 2'b10,
    FRM_D16_CRC     = 2'b11
  } frame_sel_e;

  // number of bits per frame for a given select
  function automatic len_t frame_bits(input logic [1:0] sel);
    len_t n;
    case (frame_sel_e'(sel))
      FRM_D24_CRC:     n = len_t'(32);
      FRM_D24_STS_CRC: n = len_t'(48);
      default:         n = len_t'(24);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/dspi_sync.sv
`timescale 1ns/1ps
module dspi_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/dspi_rx_path.sv
`timescale 1ns/1ps
module dspi_rx_path
  import dspi_pkg::*;
#(
  parameter int unsigned MAX_FRAME = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_fall,
  input  logic                 cs_rise,
  input  logic                 sclk_rise,
  input  logic                 active,
  input  logic                 sdi_s,
  input  len_t                 frame_len,
  output logic [MAX_FRAME-1:0] rx_sr,
  output logic [MAX_FRAME-1:0] cmd_word,
  output logic                 cmd_valid,
  output logic                 frame_err
);

  localparam len_t CNT_SAT = len_t'(MAX_FRAME);

  len_t bit_cnt;
  logic take_bit;
  logic frame_complete;

  // keep only the low `len` bits of a vector
  function automatic logic [MAX_FRAME-1:0] low_bits(input logic [MAX_FRAME-1:0] v,
                                                    input len_t len);
    logic [MAX_FRAME-1:0] m;
    for (int i = 0; i < MAX_FRAME; i++) m[i] = (len_t'(i) < len) ? v[i] : 1'b0;
    return m;
  endfunction

  assign take_bit       = active && sclk_rise;
  assign frame_complete = (bit_cnt >= frame_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr     <= '0;
      bit_cnt   <= '0;
      cmd_word  <= '0;
      cmd_valid <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      frame_err <= 1'b0;
      if (cs_fall) begin
        rx_sr   <= '0;
        bit_cnt <= '0;
      end else if (take_bit) begin
        rx_sr <= {rx_sr[MAX_FRAME-2:0], sdi_s};
        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + len_t'(1);
      end
      if (cs_rise) begin
        if (frame_complete) begin
          cmd_word  <= low_bits(rx_sr, frame_len);
          cmd_valid <= 1'b1;
        end else begin
          frame_err <= 1'b1;
        end
      end
    end
  end

  // R6
  cmd_after_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(cs_rise) && $past(frame_complete)));

  // R7
  err_excludes_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (!cmd_valid && $past(!frame_complete)));

  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable(cmd_word));

  // R5
  rx_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cs_fall) |=> $stable(rx_sr));

endmodule

// File: rtl/dspi_tx_path.sv
`timescale 1ns/1ps
module dspi_tx_path
  import dspi_pkg::*;
#(
  parameter int unsigned MAX_FRAME = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_fall,
  input  logic                 sclk_fall,
  input  logic                 active,
  input  logic                 cont_read,
  input  len_t                 load_len,
  input  len_t                 frame_len,
  input  logic [MAX_FRAME-1:0] tx_frame,
  input  logic [MAX_FRAME-1:0] rx_sr,
  output logic                 sdo_q
);

  localparam len_t CNT_SAT = len_t'(MAX_FRAME);

  logic [MAX_FRAME-1:0] tx_hold;
  len_t                 fall_cnt;
  len_t                 fall_next;
  logic                 own_phase;
  logic                 shift_out;

  // select one bit of a vector by a run-time index
  function automatic logic pick(input logic [MAX_FRAME-1:0] v, input len_t idx);
    logic b;
    b = 1'b0;
    for (int i = 0; i < MAX_FRAME; i++) if (len_t'(i) == idx) b = v[i];
    return b;
  endfunction

  assign fall_next = (fall_cnt == CNT_SAT) ? fall_cnt : fall_cnt + len_t'(1);
  assign own_phase = (fall_next < frame_len);
  assign shift_out = active && sclk_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold  <= '0;
      fall_cnt <= '0;
      sdo_q    <= 1'b1;
    end else if (cs_fall) begin
      tx_hold  <= tx_frame;
      fall_cnt <= '0;
      sdo_q    <= pick(tx_frame, load_len - len_t'(1));
    end else if (shift_out) begin
      fall_cnt <= fall_next;
      if (own_phase)      sdo_q <= pick(tx_hold, frame_len - len_t'(1) - fall_next);
      else if (cont_read) sdo_q <= 1'b1;
      else                sdo_q <= pick(rx_sr, frame_len - len_t'(1));
    end
  end

  // R10
  sdo_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_fall || shift_out) |=> $stable(sdo_q));

endmodule

// File: rtl/dspi_chain_target.sv
`timescale 1ns/1ps
module dspi_chain_target
  import dspi_pkg::*;
#(
  parameter int unsigned MAX_FRAME   = 48,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 sdi,
  output logic                 sdo,
  output logic                 sdo_oe,
  input  logic [1:0]           cfg_frame_sel,
  input  logic                 cont_read_en,
  input  logic [MAX_FRAME-1:0] tx_frame,
  output logic [MAX_FRAME-1:0] cmd_word,
  output logic                 cmd_valid,
  output logic                 frame_err
);

  logic cs_s, sclk_s, sdi_s;
  logic cs_prev, sclk_prev;
  logic cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic active_q;
  len_t len_now, len_q;
  logic [MAX_FRAME-1:0] rx_sr;

  dspi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .din(cs_n), .dout(cs_s));
  dspi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .din(sclk), .dout(sclk_s));
  dspi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sdi (
    .clk(clk), .rst_n(rst_n), .din(sdi), .dout(sdi_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      cs_prev   <= cs_s;
      sclk_prev <= sclk_s;
    end
  end

  assign cs_fall   = cs_prev & ~cs_s;
  assign cs_rise   = ~cs_prev & cs_s;
  assign sclk_rise = ~sclk_prev & sclk_s;
  assign sclk_fall = sclk_prev & ~sclk_s;
  assign len_now   = frame_bits(cfg_frame_sel);

  // frame state: selected flag and length frozen for the frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      len_q    <= len_t'(24);
    end else if (cs_fall) begin
      active_q <= 1'b1;
      len_q    <= len_now;
    end else if (cs_rise) begin
      active_q <= 1'b0;
    end
  end

  dspi_rx_path #(.MAX_FRAME(MAX_FRAME)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .active(active_q), .sdi_s(sdi_s), .frame_len(len_q),
    .rx_sr(rx_sr), .cmd_word(cmd_word), .cmd_valid(cmd_valid), .frame_err(frame_err));

  dspi_tx_path #(.MAX_FRAME(MAX_FRAME)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .sclk_fall(sclk_fall),
    .active(active_q), .cont_read(cont_read_en), .load_len(len_now), .frame_len(len_q),
    .tx_frame(tx_frame), .rx_sr(rx_sr), .sdo_q(sdo));

  assign sdo_oe = active_q;

  // R8
  oe_on_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> sdo_oe);

  // R8
  oe_off_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !sdo_oe);

endmodule

// File: tb/tb_dspi_chain_target.sv
`timescale 1ns/1ps
module tb_dspi_chain_target;

  localparam int MAXF = 48;
  localparam int HALF = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cs_n = 1'b1;
  logic            sclk = 1'b0;
  logic            sdi = 1'b1;
  logic            sdo, sdo_oe;
  logic [1:0]      cfg_frame_sel = 2'b00;
  logic            cont_read_en = 1'b0;
  logic [MAXF-1:0] tx_frame = '0;
  logic [MAXF-1:0] cmd_word;
  logic            cmd_valid, frame_err;
  logic            sdo_line;

  int n_cmp = 0;
  int n_bad = 0;
  int n_valid = 0;
  int n_err = 0;
  logic [MAXF-1:0] last_cmd = '0;
  int unsigned seed_v;

  always #2.5 clk = ~clk;

  dspi_chain_target dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .cfg_frame_sel(cfg_frame_sel),
    .cont_read_en(cont_read_en), .tx_frame(tx_frame), .cmd_word(cmd_word),
    .cmd_valid(cmd_valid), .frame_err(frame_err));

  // board pull-up on the released line
  assign sdo_line = sdo_oe ? sdo : 1'b1;

  always @(posedge clk) begin
    if (rst_n) begin
      if (cmd_valid) begin
        n_valid  <= n_valid + 1;
        last_cmd <= cmd_word;
      end
      if (frame_err) n_err <= n_err + 1;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad = n_bad + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp = n_cmp + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int blen(input logic [1:0] sel);
    if (sel == 2'b01) return 32;
    if (sel == 2'b10) return 48;
    return 24;
  endfunction

  function automatic logic [MAXF-1:0] expect_cmd(input logic [127:0] s, input int nb, input int len);
    logic [MAXF-1:0] c;
    c = '0;
    for (int j = 0; j < len; j++) c[j] = s[nb-1-j];
    return c;
  endfunction

  function automatic logic [127:0] rand_stream();
    logic [127:0] s;
    for (int k = 0; k < 4; k++) s[k*32 +: 32] = $urandom;
    return s;
  endfunction

  // SCLK toggling while deselected: must be ignored (R5)
  task automatic idle_clocks(input int n);
    for (int k = 0; k < n; k++) begin
      sdi = 1'($urandom);
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
  endtask

  task automatic run_frame(input logic [1:0] sel, input logic [MAXF-1:0] tx,
                           input int nbits, input logic [127:0] s,
                           input logic cont, input int chg_at);
    int len;
    int v0, e0;
    logic [MAXF-1:0] c0;
    logic exp;
    string tag;
    len = blen(sel);
    v0 = n_valid;
    e0 = n_err;
    c0 = last_cmd;
    cfg_frame_sel = sel;
    tx_frame = tx;
    cont_read_en = cont;
    cs_n = 1'b0;
    wait_clk(HALF);
    check("R8", "oe while selected", 64'(sdo_oe), 64'd1);
    for (int i = 0; i < nbits; i++) begin
      sdi = s[i];
      if (i == chg_at) begin
        cfg_frame_sel = (sel == 2'b10) ? 2'b01 : 2'b10;
        tx_frame = ~tx;
      end
      wait_clk(HALF);
      if (i < len) begin
        exp = tx[len-1-i];
        tag = (chg_at >= 0) ? "R1" : "R2";
      end else if (cont) begin
        exp = 1'b1;
        tag = "R4";
      end else begin
        exp = s[i-len];
        tag = "R3";
      end
      check(tag, $sformatf("sdo bit %0d", i), 64'(sdo_line), 64'(exp));
      sclk = 1'b1;
      wait_clk(HALF);
      check("R10", $sformatf("sdo held over rise %0d", i), 64'(sdo_line), 64'(exp));
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(HALF);
    check("R8", "oe after deselect", 64'(sdo_oe), 64'd0);
    check("R8", "pulled-up line", 64'(sdo_line), 64'd1);
    if (nbits >= len) begin
      check("R6", "valid pulses", 64'(n_valid - v0), 64'd1);
      check("R6", "no frame error", 64'(n_err - e0), 64'd0);
      check("R6", "command word", 64'(last_cmd), 64'(expect_cmd(s, nbits, len)));
    end else begin
      check("R7", "error pulses", 64'(n_err - e0), 64'd1);
      check("R7", "no valid", 64'(n_valid - v0), 64'd0);
      check("R7", "command kept", 64'(last_cmd), 64'(c0));
    end
  endtask

  initial begin
    logic [1:0] sel;
    int len, nb;
    seed_v = $urandom(32'd20251);
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    // R9
    check("R9", "oe after reset", 64'(sdo_oe), 64'd0);
    check("R9", "cmd after reset", 64'(cmd_word), 64'd0);
    check("R9", "valid after reset", 64'(cmd_valid), 64'd0);
    check("R9", "error after reset", 64'(frame_err), 64'd0);

    // single frame per length, then streams much longer than L (R1, R3)
    run_frame(2'b00, 48'h00AB_CDEF_0000 | 48'hABCDEF, 24, rand_stream(), 1'b0, -1);
    run_frame(2'b01, 48'h0000_DEAD_BEEF, 96, rand_stream(), 1'b0, -1);
    run_frame(2'b10, 48'hF0E1_D2C3_B4A5, 96, rand_stream(), 1'b0, -1);
    run_frame(2'b11, 48'h1234_5678_9ABC, 48, rand_stream(), 1'b0, -1);
    // R4: continuous read blocks forwarding
    run_frame(2'b00, 48'h0000_0055_AA33, 60, rand_stream(), 1'b1, -1);
    // R5: deselected clocks must not count, so a one-short frame errors
    idle_clocks(6);
    run_frame(2'b00, 48'h0000_0012_3456, 23, rand_stream(), 1'b0, -1);
    // R7: empty frame
    run_frame(2'b01, 48'h0, 0, rand_stream(), 1'b0, -1);
    // R1/R2: select and data changed mid-frame
    run_frame(2'b01, 48'h0000_C3A5_5A3C, 64, rand_stream(), 1'b0, 10);
    // exact length after deselected clocks (R5, R6)
    idle_clocks(3);
    run_frame(2'b10, 48'h8000_0000_0001, 48, rand_stream(), 1'b0, -1);

    for (int r = 0; r < 25; r++) begin
      sel = 2'($urandom);
      len = blen(sel);
      if ($urandom % 5 == 0) nb = int'($urandom % len);
      else nb = len + int'($urandom % 61);
      run_frame(sel, {$urandom, $urandom}, nb, rand_stream(), ($urandom % 4) == 0, -1);
    end

    summary();
    $finish;
  end

endmodule